// File: doc/BRIEF.md
# Output mute ramp sequencer

This block removes audible clicks when two audio outputs are muted or unmuted: the digital converter path and the headphone amplifier. Each output has a 5-bit gain that runs from 0 (silent) to 31 (full). When the mute bit for an output changes, the gain does not jump. It moves one step toward the new target on each pulse of a shared step-rate enable. The step rate is set by the surrounding logic, which pulses `tick` at the pace it wants.

When a ramp reaches its target, the block raises a one-cycle completion pulse for the interrupt logic. The converter path reports "gain up done" or "gain down done". The headphone path reports "ramp up done" or "ramp down done". A path that is held in standby does not ramp: its gain goes straight to the level its mute bit asks for, and it reports nothing.

The block takes the raw bytes of the two output control registers and of the power register. It decodes the mute bits and the standby bits from those bytes itself.

Top module: `mute_ramp_seq`

## Requirements
- R1: After a synchronous reset, both gains read 0 and all four completion pulses are low. Both paths hold an internal muted state, so a mute input of 1 at reset release starts nothing.
- R2: Field positions:
  - The mute bit of each control byte is bit 5 (1 = muted).
  - In the power byte, bit 0 puts the converter path in standby and bit 3 puts the headphone path in standby.
  - All other bits of the three bytes have no effect on gains or pulses.
- R3: A path that is ramping changes its gain by exactly one step on each cycle where `tick` is high. No gain changes in a cycle without `tick`, and an idle path ignores `tick`.
- R4: Setting the mute bit of an active path starts a ramp down to 0. Clearing it starts a ramp up to 31. The ramp begins on the clock edge that first sees the new mute value, and no step is taken on that edge.
- R5: When the converter gain reaches its target, `dac_gain_up_done` (target 31) or `dac_gain_dn_done` (target 0) is high for exactly one cycle. That cycle is the same cycle in which the gain output first shows the target.
- R6: The headphone path raises `hp_ramp_up_done` on reaching 31 and `hp_ramp_dn_done` on reaching 0. The timing is the same as in R5.
- R7: A mute change during a ramp takes priority over a `tick` in the same cycle. The ramp reverses from the current gain, and only the completion of the final direction is reported.
- R8: If a mute change asks for the level the gain already holds, the matching completion pulse is raised on the clock edge that sees the change.
- R9: While a path's standby bit is set, its gain follows its mute bit directly (0 when muted, 31 otherwise). Any ramp in progress is dropped, and that path raises no completion pulse.
- R10: The two paths are independent. Their completion pulses may occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Step-rate enable, one gain step per high cycle |
| dac_ctl | input | CTL_W | Converter control byte, mute at bit 5 |
| hp_ctl | input | CTL_W | Headphone control byte, mute at bit 5 |
| pwr_ctl | input | CTL_W | Power byte, converter standby bit 0, headphone standby bit 3 |
| dac_gain | output | GAIN_W | Current converter gain |
| hp_gain | output | GAIN_W | Current headphone gain |
| dac_gain_up_done | output | 1 | Converter ramp reached full gain |
| dac_gain_dn_done | output | 1 | Converter ramp reached zero gain |
| hp_ramp_up_done | output | 1 | Headphone ramp reached full gain |
| hp_ramp_dn_done | output | 1 | Headphone ramp reached zero gain |

## Verification
A mute reversal and the `tick` that would have ended a ramp can fall in the same cycle. The bench sets this up by unmuting the converter path and stepping it to 30. It then asserts mute together with `tick` on one cycle. The reversal must win: the gain must stay at 30 and no up-done pulse may appear. The ramp down that follows must end with exactly one down-done pulse and no up-done pulse.

// File: rtl/mute_ramp_pkg.sv
package mute_ramp_pkg;
  localparam int NUM_PATHS = 2;
  localparam int PATH_DAC  = 0;
  localparam int PATH_HP   = 1;

  typedef enum logic [1:0] {
    RAMP_IDLE = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;

  typedef struct packed {
    logic mute;
    logic standby;
  } path_ctl_t;
endpackage

// File: rtl/mute_ctl_decode.sv
module mute_ctl_decode
  import mute_ramp_pkg::*;
#(
  parameter int CTL_W      = 8,
  parameter int MUTE_BIT   = 5,
  parameter int DAC_SB_BIT = 0,
  parameter int HP_SB_BIT  = 3
) (
  input  logic [CTL_W-1:0]                dac_ctl,
  input  logic [CTL_W-1:0]                hp_ctl,
  input  logic [CTL_W-1:0]                pwr_ctl,
  output path_ctl_t [NUM_PATHS-1:0]       path_ctl
);
  // Only the mute and standby bits matter; the rest are folded here.
  logic unused_bits;
  assign unused_bits = ^{dac_ctl, hp_ctl, pwr_ctl};

  always_comb begin
    path_ctl[PATH_DAC].mute    = dac_ctl[MUTE_BIT];
    path_ctl[PATH_DAC].standby = pwr_ctl[DAC_SB_BIT];
    path_ctl[PATH_HP].mute     = hp_ctl[MUTE_BIT];
    path_ctl[PATH_HP].standby  = pwr_ctl[HP_SB_BIT];
  end
endmodule

// File: rtl/mute_ramp_chan.sv
module mute_ramp_chan
  import mute_ramp_pkg::*;
#(
  parameter int GAIN_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  path_ctl_t         ctl,
  output logic [GAIN_W-1:0] gain,
  output logic              ev_up,
  output logic              ev_dn
);
  localparam logic [GAIN_W-1:0] G_MIN = '0;
  localparam logic [GAIN_W-1:0] G_MAX = '1;
  localparam logic [GAIN_W-1:0] G_ONE = 1;

  logic [GAIN_W-1:0] gain_q;
  logic              mute_q;
  ramp_dir_e         dir_q;
  logic              ev_up_q;
  logic              ev_dn_q;

  logic [GAIN_W-1:0] tgt;
  logic [GAIN_W-1:0] gain_inc;
  logic [GAIN_W-1:0] gain_dec;
  logic              mute_chg;

  assign tgt      = ctl.mute ? G_MIN : G_MAX;
  assign gain_inc = gain_q + G_ONE;
  assign gain_dec = gain_q - G_ONE;
  assign mute_chg = ctl.mute ^ mute_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q  <= G_MIN;
      mute_q  <= 1'b1;
      dir_q   <= RAMP_IDLE;
      ev_up_q <= 1'b0;
      ev_dn_q <= 1'b0;
    end else begin
      ev_up_q <= 1'b0;
      ev_dn_q <= 1'b0;
      mute_q  <= ctl.mute;
      if (ctl.standby) begin
        // Powered-down path: jump to the requested level, stay silent.
        gain_q <= tgt;
        dir_q  <= RAMP_IDLE;
      end else if (mute_chg) begin
        if (gain_q == tgt) begin
          dir_q   <= RAMP_IDLE;
          ev_up_q <= ~ctl.mute;
          ev_dn_q <= ctl.mute;
        end else begin
          dir_q <= ctl.mute ? RAMP_DOWN : RAMP_UP;
        end
      end else if (tick) begin
        case (dir_q)
          RAMP_UP: begin
            gain_q <= gain_inc;
            if (gain_inc == G_MAX) begin
              dir_q   <= RAMP_IDLE;
              ev_up_q <= 1'b1;
            end
          end
          RAMP_DOWN: begin
            gain_q <= gain_dec;
            if (gain_dec == G_MIN) begin
              dir_q   <= RAMP_IDLE;
              ev_dn_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign gain  = gain_q;
  assign ev_up = ev_up_q;
  assign ev_dn = ev_dn_q;
endmodule

// File: rtl/mute_ramp_seq.sv
module mute_ramp_seq
  import mute_ramp_pkg::*;
#(
  parameter int GAIN_W     = 5,
  parameter int CTL_W      = 8,
  parameter int MUTE_BIT   = 5,
  parameter int DAC_SB_BIT = 0,
  parameter int HP_SB_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CTL_W-1:0]  dac_ctl,
  input  logic [CTL_W-1:0]  hp_ctl,
  input  logic [CTL_W-1:0]  pwr_ctl,
  output logic [GAIN_W-1:0] dac_gain,
  output logic [GAIN_W-1:0] hp_gain,
  output logic              dac_gain_up_done,
  output logic              dac_gain_dn_done,
  output logic              hp_ramp_up_done,
  output logic              hp_ramp_dn_done
);
  path_ctl_t [NUM_PATHS-1:0] path_ctl;
  logic [GAIN_W-1:0]         gain_a [NUM_PATHS];
  logic [NUM_PATHS-1:0]      up_a;
  logic [NUM_PATHS-1:0]      dn_a;

  mute_ctl_decode #(
    .CTL_W(CTL_W), .MUTE_BIT(MUTE_BIT),
    .DAC_SB_BIT(DAC_SB_BIT), .HP_SB_BIT(HP_SB_BIT)
  ) u_dec (
    .dac_ctl (dac_ctl),
    .hp_ctl  (hp_ctl),
    .pwr_ctl (pwr_ctl),
    .path_ctl(path_ctl)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    mute_ramp_chan #(.GAIN_W(GAIN_W)) u_chan (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .ctl  (path_ctl[p]),
      .gain (gain_a[p]),
      .ev_up(up_a[p]),
      .ev_dn(dn_a[p])
    );
  end

  assign dac_gain         = gain_a[PATH_DAC];
  assign hp_gain          = gain_a[PATH_HP];
  assign dac_gain_up_done = up_a[PATH_DAC];
  assign dac_gain_dn_done = dn_a[PATH_DAC];
  assign hp_ramp_up_done  = up_a[PATH_HP];
  assign hp_ramp_dn_done  = dn_a[PATH_HP];
endmodule

// File: rtl/mute_ramp_seq_chk.sv
module mute_ramp_seq_chk #(
  parameter int GAIN_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              dac_sb,
  input logic              hp_sb,
  input logic [GAIN_W-1:0] dac_gain,
  input logic [GAIN_W-1:0] hp_gain,
  input logic              dac_gain_up_done,
  input logic              dac_gain_dn_done,
  input logic              hp_ramp_up_done,
  input logic              hp_ramp_dn_done
);
  localparam logic [GAIN_W-1:0] G_ONE = 1;
  logic rst_d;

  always_ff @(posedge clk) rst_d <= rst;

  // R1: one cycle after a reset edge everything is at rest.
  always_ff @(posedge clk) begin
    if (rst_d === 1'b1) begin
      a_r1_reset_state: assert (dac_gain == '0 && hp_gain == '0 &&
        !dac_gain_up_done && !dac_gain_dn_done &&
        !hp_ramp_up_done && !hp_ramp_dn_done);
    end
  end

  a_r3_dac_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !dac_sb) |=> $stable(dac_gain));
  a_r3_hp_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !hp_sb) |=> $stable(hp_gain));

  a_r3_dac_single_step: assert property (@(posedge clk) disable iff (rst)
    !dac_sb |=> (dac_gain == $past(dac_gain) ||
                 dac_gain == $past(dac_gain) + G_ONE ||
                 dac_gain == $past(dac_gain) - G_ONE));
  a_r3_hp_single_step: assert property (@(posedge clk) disable iff (rst)
    !hp_sb |=> (hp_gain == $past(hp_gain) ||
                hp_gain == $past(hp_gain) + G_ONE ||
                hp_gain == $past(hp_gain) - G_ONE));

  a_r5_dac_up_at_max: assert property (@(posedge clk) disable iff (rst)
    dac_gain_up_done |-> dac_gain == '1);
  a_r5_dac_dn_at_zero: assert property (@(posedge clk) disable iff (rst)
    dac_gain_dn_done |-> dac_gain == '0);
  a_r5_dac_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dac_gain_up_done, dac_gain_dn_done}));
  a_r5_dac_up_pulse: assert property (@(posedge clk) disable iff (rst)
    dac_gain_up_done |=> !dac_gain_up_done);

  a_r6_hp_up_at_max: assert property (@(posedge clk) disable iff (rst)
    hp_ramp_up_done |-> hp_gain == '1);
  a_r6_hp_dn_at_zero: assert property (@(posedge clk) disable iff (rst)
    hp_ramp_dn_done |-> hp_gain == '0);
  a_r6_hp_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hp_ramp_up_done, hp_ramp_dn_done}));

  a_r9_dac_quiet_standby: assert property (@(posedge clk) disable iff (rst)
    dac_sb |=> !(dac_gain_up_done || dac_gain_dn_done));
  a_r9_hp_quiet_standby: assert property (@(posedge clk) disable iff (rst)
    hp_sb |=> !(hp_ramp_up_done || hp_ramp_dn_done));
endmodule

bind mute_ramp_seq mute_ramp_seq_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .tick            (tick),
  .dac_sb          (pwr_ctl[DAC_SB_BIT]),
  .hp_sb           (pwr_ctl[HP_SB_BIT]),
  .dac_gain        (dac_gain),
  .hp_gain         (hp_gain),
  .dac_gain_up_done(dac_gain_up_done),
  .dac_gain_dn_done(dac_gain_dn_done),
  .hp_ramp_up_done (hp_ramp_up_done),
  .hp_ramp_dn_done (hp_ramp_dn_done)
);

// File: tb/mute_ramp_seq_test.sv
module mute_ramp_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] dac_ctl = 8'h20;
  logic [7:0] hp_ctl = 8'h20;
  logic [7:0] pwr_ctl = 8'h00;
  logic [4:0] dac_gain, hp_gain;
  logic       dac_gain_up_done, dac_gain_dn_done;
  logic       hp_ramp_up_done, hp_ramp_dn_done;

  int checks = 0;
  int fails = 0;
  int n_du = 0, n_dd = 0, n_hu = 0, n_hd = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mute_ramp_seq uut (
    .clk(clk), .rst(rst), .tick(tick),
    .dac_ctl(dac_ctl), .hp_ctl(hp_ctl), .pwr_ctl(pwr_ctl),
    .dac_gain(dac_gain), .hp_gain(hp_gain),
    .dac_gain_up_done(dac_gain_up_done), .dac_gain_dn_done(dac_gain_dn_done),
    .hp_ramp_up_done(hp_ramp_up_done), .hp_ramp_dn_done(hp_ramp_dn_done)
  );

  // Pulse counters, sampled just after each active edge.
  always begin
    @(posedge clk);
    #1;
    if (!rst) begin
      n_du += int'(dac_gain_up_done);
      n_dd += int'(dac_gain_dn_done);
      n_hu += int'(hp_ramp_up_done);
      n_hd += int'(hp_ramp_dn_done);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic clr();
    n_du = 0; n_dd = 0; n_hu = 0; n_hd = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic t_reset();
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 dac gain", dac_gain, 0);
    chk("R1 hp gain", hp_gain, 0);
    chk("R1 pulses", {dac_gain_up_done, dac_gain_dn_done,
                      hp_ramp_up_done, hp_ramp_dn_done}, 0);
    cyc(2);
    chk("R1 no start from muted input", n_du + n_dd + n_hu + n_hd, 0);
  endtask

  task automatic t_unmute_dac();
    clr();
    dac_ctl = 8'h00;
    cyc(1);
    cyc(3);
    chk("R3 no step without tick", dac_gain, 0);
    ticks(30);
    chk("R4 ramp up position", dac_gain, 30);
    chk("R5 no early up-done", n_du, 0);
    ticks(1);
    chk("R5 gain at target", dac_gain, 31);
    chk("R5 up-done same cycle", dac_gain_up_done, 1);
    cyc(1);
    chk("R5 up-done single cycle", dac_gain_up_done, 0);
    chk("R5 up-done count", n_du, 1);
    chk("R10 hp untouched", hp_gain, 0);
    ticks(2);
    chk("R3 idle ignores tick", dac_gain, 31);
  endtask

  task automatic t_cross();
    clr();
    dac_ctl = 8'h20;
    hp_ctl  = 8'h00;
    cyc(1);
    ticks(30);
    chk("R10 dac descending", dac_gain, 1);
    chk("R10 hp ascending", hp_gain, 30);
    ticks(1);
    chk("R10 dac dn-done coincident", dac_gain_dn_done, 1);
    chk("R6 hp up-done coincident", hp_ramp_up_done, 1);
    chk("R6 hp at max", hp_gain, 31);
    cyc(1);
    chk("R10 pulse counts", n_dd * 10 + n_hu, 11);
    clr();
    hp_ctl = 8'h20;
    cyc(1);
    ticks(31);
    chk("R6 hp at zero", hp_gain, 0);
    cyc(1);
    chk("R6 hp dn-done count", n_hd, 1);
    chk("R6 hp no up-done", n_hu, 0);
  endtask

  task automatic t_reverse();
    clr();
    dac_ctl = 8'h00;
    cyc(1);
    ticks(30);
    chk("R7 pre-reversal gain", dac_gain, 30);
    dac_ctl = 8'h20;
    tick = 1'b1;
    cyc(1);
    tick = 1'b0;
    chk("R7 change beats tick", dac_gain, 30);
    chk("R7 no up-done on reversal", dac_gain_up_done, 0);
    ticks(30);
    chk("R7 reversed to zero", dac_gain, 0);
    cyc(1);
    chk("R7 only final dn-done", n_dd, 1);
    chk("R7 no up-done", n_du, 0);
  endtask

  task automatic t_immediate();
    clr();
    dac_ctl = 8'h00;
    cyc(1);
    dac_ctl = 8'h20;
    cyc(1);
    chk("R8 immediate dn-done", dac_gain_dn_done, 1);
    chk("R8 gain unchanged", dac_gain, 0);
    cyc(1);
    chk("R8 counts", n_dd * 10 + n_du, 10);
  endtask

  task automatic t_standby();
    clr();
    pwr_ctl = 8'h01;
    cyc(1);
    dac_ctl = 8'h00;
    cyc(1);
    chk("R9 snap to full", dac_gain, 31);
    dac_ctl = 8'h20;
    cyc(1);
    chk("R9 snap to zero", dac_gain, 0);
    pwr_ctl = 8'h00;
    cyc(1);
    dac_ctl = 8'h00;
    cyc(1);
    ticks(5);
    chk("R9 ramp after standby", dac_gain, 5);
    pwr_ctl = 8'h01;
    cyc(1);
    chk("R9 standby drops ramp", dac_gain, 31);
    pwr_ctl = 8'h00;
    cyc(1);
    ticks(3);
    chk("R9 stays after leave", dac_gain, 31);
    chk("R9 no pulses", n_du + n_dd + n_hu + n_hd, 0);
  endtask

  task automatic t_fields();
    clr();
    dac_ctl = 8'hDF;
    hp_ctl  = 8'hFF;
    pwr_ctl = 8'hF6;
    cyc(3);
    ticks(2);
    chk("R2 other bits ignored dac", dac_gain, 31);
    chk("R2 other bits ignored hp", hp_gain, 0);
    chk("R2 no pulses", n_du + n_dd + n_hu + n_hd, 0);
    pwr_ctl = 8'h08;
    hp_ctl  = 8'h00;
    cyc(1);
    chk("R2 hp standby bit 3", hp_gain, 31);
    chk("R2 dac unaffected", dac_gain, 31);
    pwr_ctl = 8'h01;
    dac_ctl = 8'h20;
    cyc(1);
    chk("R2 dac standby bit 0", dac_gain, 0);
    chk("R2 hp kept", hp_gain, 31);
    cyc(1);
    chk("R2 still no pulses", n_du + n_dd + n_hu + n_hd, 0);
  endtask

  initial begin
    t_reset();
    t_unmute_dac();
    t_cross();
    t_reverse();
    t_immediate();
    t_standby();
    t_fields();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
    end
  end
endmodule